// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits in a two-wide decode stage and decides, every cycle, whether the two decoded instructions presented to it can leave together. One goes to a full-function first pipe and one to a restricted second pipe. The decision is made before register file read. The block sees two slots in program order: an older slot and a younger slot. Each slot describes its instruction with these fields:

- a destination register and its valid bit;
- for the younger slot, two source registers, each with a valid bit;
- an operation class;
- a mask of shared execution resources.

The two instructions are paired only under three conditions. The younger one must not depend on the older one through a register. The two must not claim the same shared resource. The younger one's operation class must be one the second pipe can execute.

When pairing is refused, only the older instruction goes to the first pipe. The block then raises a hold flag, so that the front end re-presents the younger instruction as the older slot in the following cycle. A single valid instruction always goes to the first pipe. A select output reports which slot the first pipe is carrying.

The decision is registered once: outputs reflect the inputs sampled at the previous rising clock edge.

Top module: `pair_check`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, issue_u, issue_v, hold and u_slot are all 0.
- R2: Outputs are registered: the values seen after a rising edge are the decision for the slot inputs sampled at that edge.
- R3: With both slots valid, the pair is refused if a younger source whose valid bit is 1 equals the older destination while the older destination valid bit is 1 (read-after-write).
- R4: With both slots valid, the pair is refused if both destination valid bits are 1 and the two destination registers are equal (write-after-write).
- R5: With both slots valid, the pair is refused if the bitwise AND of the two resource masks is non-zero.
- R6: With both slots valid, the pair is refused if bit y_op of parameter V_OPS is 0. With the defaults, classes 0 to 3 are second-pipe capable and classes 4 to 7 are not.
- R7: A refused pair gives issue_u=1, issue_v=0, hold=1, u_slot=0. An accepted pair gives issue_u=1, issue_v=1, hold=0, u_slot=0.
- R8: If only the older slot is valid, the result is issue_u=1, issue_v=0, hold=0, u_slot=0. If only the younger slot is valid, the result is issue_u=1, issue_v=0, hold=0, u_slot=1. If neither is valid, all four outputs are 0.
- R9: A register match whose source or destination valid bit is 0 does not refuse the pair, and neither do any field values of an invalid slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| o_vld | input | 1 | Older slot valid |
| o_dst | input | REG_W | Older destination register |
| o_dst_v | input | 1 | Older destination used |
| o_res | input | RES_W | Older shared-resource mask |
| y_vld | input | 1 | Younger slot valid |
| y_dst | input | REG_W | Younger destination register |
| y_dst_v | input | 1 | Younger destination used |
| y_sa | input | REG_W | Younger first source register |
| y_sa_v | input | 1 | Younger first source used |
| y_sb | input | REG_W | Younger second source register |
| y_sb_v | input | 1 | Younger second source used |
| y_op | input | OPC_W | Younger operation class |
| y_res | input | RES_W | Younger shared-resource mask |
| issue_u | output | 1 | An instruction leaves on the first pipe |
| issue_v | output | 1 | The younger instruction leaves on the second pipe |
| hold | output | 1 | Younger instruction kept for the next cycle's older slot |
| u_slot | output | 1 | Slot carried by the first pipe: 0 older, 1 younger |

## Verification
The bench builds the block with its default parameters: 5-bit register indices, 3-bit operation classes, a 4-bit resource mask, and second-pipe classes 0 to 3. These values put every refusal cause within reach of random stimulus. Register indices are drawn from a narrow range so that read-after-write and write-after-write matches happen often, and each valid bit is toggled independently. That makes masked matches under R9 as likely as real ones. Directed cases isolate each refusal cause alone, and every combination of slot validity.

// File: rtl/pair_check.sv
module pair_check #(
  parameter int REG_W = 5,
  parameter int OPC_W = 3,
  parameter int RES_W = 4,
  parameter logic [(1<<OPC_W)-1:0] V_OPS = 8'b0000_1111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             o_vld,
  input  logic [REG_W-1:0] o_dst,
  input  logic             o_dst_v,
  input  logic [RES_W-1:0] o_res,
  input  logic             y_vld,
  input  logic [REG_W-1:0] y_dst,
  input  logic             y_dst_v,
  input  logic [REG_W-1:0] y_sa,
  input  logic             y_sa_v,
  input  logic [REG_W-1:0] y_sb,
  input  logic             y_sb_v,
  input  logic [OPC_W-1:0] y_op,
  input  logic [RES_W-1:0] y_res,
  output logic             issue_u,
  output logic             issue_v,
  output logic             hold,
  output logic             u_slot
);
  logic raw_a, raw_b, waw, res_hit, v_ok, both, pair_ok;

  assign raw_a   = y_sa_v && o_dst_v && (y_sa == o_dst);
  assign raw_b   = y_sb_v && o_dst_v && (y_sb == o_dst);
  assign waw     = y_dst_v && o_dst_v && (y_dst == o_dst);
  assign res_hit = |(o_res & y_res);
  assign v_ok    = V_OPS[y_op];
  assign both    = o_vld && y_vld;
  assign pair_ok = both && !raw_a && !raw_b && !waw && !res_hit && v_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_u <= 1'b0;
      issue_v <= 1'b0;
      hold    <= 1'b0;
      u_slot  <= 1'b0;
    end else begin
      issue_u <= o_vld || y_vld;
      issue_v <= pair_ok;
      hold    <= both && !pair_ok;
      u_slot  <= !o_vld && y_vld;
    end
  end
endmodule

module pair_check_sva #(
  parameter int REG_W = 5,
  parameter int OPC_W = 3,
  parameter int RES_W = 4,
  parameter logic [(1<<OPC_W)-1:0] V_OPS = 8'b0000_1111
) (
  input logic             clk,
  input logic             rst_n,
  input logic             o_vld,
  input logic [REG_W-1:0] o_dst,
  input logic             o_dst_v,
  input logic [RES_W-1:0] o_res,
  input logic             y_vld,
  input logic [REG_W-1:0] y_dst,
  input logic             y_dst_v,
  input logic [REG_W-1:0] y_sa,
  input logic             y_sa_v,
  input logic [REG_W-1:0] y_sb,
  input logic             y_sb_v,
  input logic [OPC_W-1:0] y_op,
  input logic [RES_W-1:0] y_res,
  input logic             issue_u,
  input logic             issue_v,
  input logic             hold,
  input logic             u_slot
);
  // R7
  v_needs_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> issue_u && !u_slot);
  // R7
  hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> issue_u && !issue_v);
  // R5
  no_shared_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> $past((o_res & y_res) == '0));
  // R3
  no_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> $past(!(o_dst_v && y_sa_v && y_sa == o_dst) &&
                      !(o_dst_v && y_sb_v && y_sb == o_dst)));
  // R4
  no_waw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> $past(!(o_dst_v && y_dst_v && y_dst == o_dst)));
  // R6
  v_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> $past(V_OPS[y_op]));
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!o_vld && !y_vld) |-> !issue_u && !hold);
  // R1
  reset_chk: assert property (@(posedge clk)
    !rst_n |=> !issue_u && !issue_v && !hold && !u_slot);
endmodule

bind pair_check pair_check_sva #(.REG_W(REG_W), .OPC_W(OPC_W), .RES_W(RES_W), .V_OPS(V_OPS)) u_sva (.*);

// File: tb/tb_pair_check.sv
`timescale 1ns/1ps
module tb_pair_check;
  localparam int REG_W = 5, OPC_W = 3, RES_W = 4;
  localparam logic [7:0] VOPS = 8'b0000_1111;

  logic clk = 0, rst_n = 0;
  logic o_vld, o_dst_v, y_vld, y_dst_v, y_sa_v, y_sb_v;
  logic [REG_W-1:0] o_dst, y_dst, y_sa, y_sb;
  logic [OPC_W-1:0] y_op;
  logic [RES_W-1:0] o_res, y_res;
  logic issue_u, issue_v, hold, u_slot;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pair_check dut (.*);

  function automatic logic [3:0] model();
    logic dep, ok;
    dep = (o_dst_v && y_sa_v && y_sa == o_dst) || (o_dst_v && y_sb_v && y_sb == o_dst) ||
          (o_dst_v && y_dst_v && y_dst == o_dst);
    ok  = o_vld && y_vld && !dep && ((o_res & y_res) == 0) && VOPS[y_op];
    return {o_vld || y_vld, ok, o_vld && y_vld && !ok, !o_vld && y_vld};
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    tests++;
    if ({issue_u, issue_v, hold, u_slot} !== exp) begin
      fails++;
      $display("FAIL %s: got u/v/h/s=%b expected %b", tag, {issue_u, issue_v, hold, u_slot}, exp);
    end
  endtask

  task automatic clear();
    o_vld = 0; o_dst = 0; o_dst_v = 0; o_res = 0;
    y_vld = 0; y_dst = 0; y_dst_v = 0; y_sa = 0; y_sa_v = 0;
    y_sb = 0; y_sb_v = 0; y_op = 0; y_res = 0;
  endtask

  task automatic base_pair();
    clear();
    o_vld = 1; o_dst = 5'd1; o_dst_v = 1; o_res = 4'b0001;
    y_vld = 1; y_dst = 5'd2; y_dst_v = 1; y_sa = 5'd3; y_sa_v = 1;
    y_sb = 5'd4; y_sb_v = 1; y_op = 3'd1; y_res = 4'b0010;
  endtask

  task automatic step(input logic [3:0] exp, input string tag);
    @(posedge clk); @(negedge clk);
    check(exp, tag);
  endtask

  initial begin
    clear();
    @(negedge clk); check(4'b0000, "R1 in reset");
    @(negedge clk); check(4'b0000, "R1 in reset 2");
    o_vld = 1; rst_n = 1;
    @(negedge clk); check(4'b1000, "R2 first sample");
    rst_n = 0; #1; check(4'b0000, "R1 async reset");
    @(negedge clk); rst_n = 1; clear();
    @(negedge clk); check(4'b0000, "R8 idle");

    base_pair(); step(4'b1100, "R7 accepted pair");
    base_pair(); y_sa = 5'd1; step(4'b1010, "R3 raw on src a");
    base_pair(); y_sb = 5'd1; step(4'b1010, "R3 raw on src b");
    base_pair(); y_dst = 5'd1; step(4'b1010, "R4 waw");
    base_pair(); y_res = 4'b0011; step(4'b1010, "R5 resource clash");
    base_pair(); y_op = 3'd4; step(4'b1010, "R6 class 4 not v capable");
    base_pair(); y_op = 3'd3; step(4'b1100, "R6 class 3 v capable");
    base_pair(); y_op = 3'd7; step(4'b1010, "R6 class 7 not v capable");
    base_pair(); y_sa = 5'd1; y_sa_v = 0; step(4'b1100, "R9 src a invalid");
    base_pair(); y_sb = 5'd1; y_sb_v = 0; y_dst = 5'd1; y_dst_v = 0; step(4'b1100, "R9 src b and dst invalid");
    base_pair(); y_sa = 5'd1; o_dst_v = 0; step(4'b1100, "R9 older dst invalid");
    base_pair(); y_vld = 0; step(4'b1000, "R8 older only");
    base_pair(); o_vld = 0; step(4'b1001, "R8 younger only");
    base_pair(); y_vld = 0; y_op = 3'd7; y_res = 4'b0001; step(4'b1000, "R9 invalid younger fields");
    base_pair(); o_vld = 0; o_res = 4'b0010; y_sa = 5'd1; step(4'b1001, "R9 invalid older fields");

    void'($urandom(32'd1234));
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] e;
      o_vld = ($urandom_range(0, 7) != 0); y_vld = ($urandom_range(0, 7) != 0);
      o_dst = REG_W'($urandom_range(0, 3)); o_dst_v = $urandom_range(0, 1);
      y_dst = REG_W'($urandom_range(0, 3)); y_dst_v = $urandom_range(0, 1);
      y_sa = REG_W'($urandom_range(0, 3)); y_sa_v = $urandom_range(0, 1);
      y_sb = REG_W'($urandom_range(0, 3)); y_sb_v = $urandom_range(0, 1);
      y_op = OPC_W'($urandom_range(0, 7));
      o_res = RES_W'($urandom_range(0, 15) & $urandom_range(0, 15));
      y_res = RES_W'($urandom_range(0, 15) & $urandom_range(0, 15));
      e = model();
      step(e, "R2 R3 R4 R5 R6 R7 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule